// File: doc/BRIEF.md
# DMA Interrupt Control and Status Register

This block is the one shared interrupt register of a multi-channel DMA engine. It holds three kinds of bits. Some are control bits that software writes directly: six spare bits, a force bit, per-channel interrupt enables and a global enable. Some are per-channel completion flags that software clears by writing one to them. The last is a read-only master bit. Channel transfer logic lives elsewhere and reports each finished transfer to this block as a one-cycle pulse. A flag is latched only while that channel's enable is set.

On every cycle the block works out the master condition from the state that results from any write and any completion pulse in that cycle. The condition is true when the force bit is set, or when the global enable is set and at least one flag is set. It mirrors the condition in bit 31. It sends a single-cycle set pulse to the system interrupt controller only when the condition rises, so a condition that stays true raises no further requests. When the condition falls, bit 31 clears and the next rise gives a new pulse.

Software sees the register as one 32-bit word at a fixed word offset. Bit 31 cannot be written, so the write data port carries bits 30:0 only. The number of channels can be set from one to seven. Enable and flag bits of channels that do not exist read as zero.

Top module: `dma_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all 32 bits of the readback word and holds `irq_set` low.
- R2: A write (wr_en high, wr_addr equal to REG_OFFSET, default 0x0F4) loads readback bits 5:0 (spare), bit 15 (force), bits 16+n (enable of channel n) and bit 23 (global enable) from the written value in the next cycle. Bits 14:6 always read zero.
- R3: A pulse on ch_done[n] sets flag bit 24+n in the next cycle only if enable bit 16+n was set before that cycle. A pulse while the enable is clear leaves the flag at zero.
- R4: Writing 1 to flag bit 24+n clears that flag, and writing 0 leaves it unchanged. When a clear and a latched completion on the same channel fall in the same cycle, the flag ends up set.
- R5: Readback bit 31 equals (bit 23 AND any of bits 30:24) OR bit 15 of the same readback word.
- R6: `irq_set` is high for exactly one cycle, in the cycle where bit 31 first reads 1 after reading 0. While bit 31 stays at 1, `irq_set` stays low, even across writes and new flags.
- R7: Once the master condition is false, bit 31 reads 0. A later rise of the condition produces a new `irq_set` pulse.
- R8: A write whose address is not REG_OFFSET, or a cycle with wr_en low, changes no bit of the readback word.
- R9: For channels n >= NUM_CH, enable bit 16+n and flag bit 24+n read zero, whatever value is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 31 | Write data, bits 30:0 (bit 31 is read-only) |
| ch_done | input | NUM_CH | One-cycle completion pulse per channel |
| rd_data | output | 32 | Current register value |
| irq_set | output | 1 | One-cycle request to the system interrupt controller |

## Verification
The bench builds the block with NUM_CH = 5 and the default address width and offset. Channels 5 and 6 therefore do not exist, and writing all ones to the enable and flag fields shows that their bits stay at zero. Five real channels are still enough to mix flagged and unflagged channels, to clear one flag out of several while others keep the master condition high, and to race a write-one clear against a completion on the same channel. The table also covers a completion that arrives together with the write that turns its enable off, which shows that the enable held before the write is the one that gates the flag.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned MAX_CH    = 7;
    localparam int unsigned CTRL_W    = 24;
    localparam int unsigned SPARE_W   = 6;
    localparam int unsigned FORCE_POS = 15;
    localparam int unsigned EN_POS    = 16;
    localparam int unsigned GLB_POS   = 23;
    localparam int unsigned FLAG_POS  = 24;

    // Which channel slots exist for a given channel count
    function automatic logic [MAX_CH-1:0] chan_mask(int unsigned nch);
        logic [MAX_CH-1:0] m;
        m = '0;
        for (int i = 0; i < MAX_CH; i++) begin
            if (i < nch) m[i] = 1'b1;
        end
        return m;
    endfunction

    // Bits of the control half (23:0) that a write may load
    function automatic logic [CTRL_W-1:0] ctrl_mask(int unsigned nch);
        logic [CTRL_W-1:0] m;
        m = '0;
        m[SPARE_W-1:0]       = '1;
        m[FORCE_POS]         = 1'b1;
        m[EN_POS +: MAX_CH]  = chan_mask(nch);
        m[GLB_POS]           = 1'b1;
        return m;
    endfunction

    // Decoded write: whether it targets this register, and the control
    // half as it stands after this cycle
    typedef struct packed {
        logic              hit;
        logic [CTRL_W-1:0] nxt_ctrl;
    } wr_req_t;

endpackage

// File: rtl/dma_irq_wr_decode.sv
module dma_irq_wr_decode
    import dma_irq_pkg::*;
#(
    parameter int unsigned        NUM_CH     = 7,
    parameter int unsigned        ADDR_W     = 12,
    parameter logic [ADDR_W-1:0]  REG_OFFSET = 12'h0F4
) (
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [WORD_W-2:0]    wr_data,
    input  logic [CTRL_W-1:0]    ctrl_q,
    output wr_req_t              req,
    output logic [NUM_CH-1:0]    clr
);

    localparam logic [CTRL_W-1:0] LOAD_MASK = ctrl_mask(NUM_CH);

    always_comb begin
        req.hit      = wr_en && (wr_addr == REG_OFFSET);
        req.nxt_ctrl = req.hit ? (wr_data[CTRL_W-1:0] & LOAD_MASK) : ctrl_q;
        clr          = req.hit ? wr_data[FLAG_POS +: NUM_CH] : '0;
    end

endmodule

// File: rtl/dma_irq_flag_bank.sv
module dma_irq_flag_bank #(
    parameter int unsigned NUM_CH = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ch_done,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] clr,
    output logic [NUM_CH-1:0] flags_q,
    output logic [NUM_CH-1:0] flags_nx
);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_flag
        logic latch_evt;

        always_comb begin
            latch_evt   = ch_done[n] & ch_en[n];
            // a latched completion wins over a same-cycle clear
            flags_nx[n] = (flags_q[n] & ~clr[n]) | latch_evt;
        end

        always_ff @(posedge clk) begin
            if (rst) flags_q[n] <= 1'b0;
            else     flags_q[n] <= flags_nx[n];
        end

        p_flag_set_r3: assert property (@(posedge clk) disable iff (rst)
            (ch_done[n] && ch_en[n]) |=> flags_q[n])
            else $error("flag %0d not latched", n);

        p_flag_clear_r4: assert property (@(posedge clk) disable iff (rst)
            (clr[n] && !(ch_done[n] && ch_en[n])) |=> !flags_q[n])
            else $error("flag %0d not cleared", n);

        p_flag_hold_r4: assert property (@(posedge clk) disable iff (rst)
            (!clr[n] && !(ch_done[n] && ch_en[n])) |=> $stable(flags_q[n]))
            else $error("flag %0d changed without cause", n);
    end

endmodule

// File: rtl/dma_irq_edge.sv
module dma_irq_edge (
    input  logic clk,
    input  logic rst,
    input  logic glb_nx,
    input  logic force_nx,
    input  logic any_flag_nx,
    output logic sent_q,
    output logic irq_set_q
);

    logic master_nx;

    always_comb begin
        master_nx = (glb_nx & any_flag_nx) | force_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sent_q    <= 1'b0;
            irq_set_q <= 1'b0;
        end else begin
            sent_q    <= master_nx;
            irq_set_q <= master_nx & ~sent_q;
        end
    end

    p_pulse_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
        irq_set_q |-> (sent_q && !$past(sent_q)))
        else $error("request without a rising master bit");

    p_rise_gives_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        (sent_q && !$past(sent_q)) |-> irq_set_q)
        else $error("rising master bit without request");

    p_sent_drops_r7: assert property (@(posedge clk) disable iff (rst)
        (sent_q && !master_nx) |=> (!sent_q && !irq_set_q))
        else $error("master bit did not drop");

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dma_irq_pkg::*;
#(
    parameter int unsigned        NUM_CH     = 7,
    parameter int unsigned        ADDR_W     = 12,
    parameter logic [ADDR_W-1:0]  REG_OFFSET = 12'h0F4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [WORD_W-2:0]    wr_data,
    input  logic [NUM_CH-1:0]    ch_done,
    output logic [WORD_W-1:0]    rd_data,
    output logic                 irq_set
);

    localparam logic [CTRL_W-1:0] LOAD_MASK = ctrl_mask(NUM_CH);

    logic [CTRL_W-1:0] ctrl_q;
    wr_req_t           req;
    logic [NUM_CH-1:0] clr;
    logic [NUM_CH-1:0] flags_q;
    logic [NUM_CH-1:0] flags_nx;
    logic [MAX_CH-1:0] flags_word;
    logic              sent_q;

    dma_irq_wr_decode #(
        .NUM_CH     (NUM_CH),
        .ADDR_W     (ADDR_W),
        .REG_OFFSET (REG_OFFSET)
    ) i_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .req     (req),
        .clr     (clr)
    );

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= req.nxt_ctrl;
    end

    // enables as held before this cycle gate the completions
    dma_irq_flag_bank #(
        .NUM_CH (NUM_CH)
    ) i_flags (
        .clk      (clk),
        .rst      (rst),
        .ch_done  (ch_done),
        .ch_en    (ctrl_q[EN_POS +: NUM_CH]),
        .clr      (clr),
        .flags_q  (flags_q),
        .flags_nx (flags_nx)
    );

    dma_irq_edge i_edge (
        .clk         (clk),
        .rst         (rst),
        .glb_nx      (req.nxt_ctrl[GLB_POS]),
        .force_nx    (req.nxt_ctrl[FORCE_POS]),
        .any_flag_nx (|flags_nx),
        .sent_q      (sent_q),
        .irq_set_q   (irq_set)
    );

    always_comb begin
        flags_word             = '0;
        flags_word[NUM_CH-1:0] = flags_q;
        rd_data                = {sent_q, flags_word, ctrl_q};
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (rd_data == '0 && !irq_set))
        else $error("register not cleared by reset");

    p_write_load_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == REG_OFFSET) |=>
            (rd_data[CTRL_W-1:0] == ($past(wr_data[CTRL_W-1:0]) & LOAD_MASK)))
        else $error("control half does not match write");

    p_master_bit_r5: assert property (@(posedge clk) disable iff (rst)
        rd_data[31] == ((rd_data[GLB_POS] && (|rd_data[30:FLAG_POS])) || rd_data[FORCE_POS]))
        else $error("master bit inconsistent with readback");

    p_no_write_no_change_r8: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && wr_addr == REG_OFFSET) && ch_done == '0) |=> $stable(rd_data))
        else $error("readback changed without write or completion");

endmodule

// File: tb/test_dma_irq_ctrl.sv
`timescale 1ns/1ps
module test_dma_irq_ctrl;

    localparam int unsigned NCH = 5;
    localparam logic [11:0] OFS = 12'h0F4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [11:0]       wr_addr = '0;
    logic [30:0]       wr_data = '0;
    logic [NCH-1:0]    ch_done = '0;
    logic [31:0]       rd_data;
    logic              irq_set;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    dma_irq_ctrl #(
        .NUM_CH     (NCH),
        .ADDR_W     (12),
        .REG_OFFSET (OFS)
    ) i_dma_irq_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ch_done (ch_done),
        .rd_data (rd_data),
        .irq_set (irq_set)
    );

    typedef struct packed {
        logic        we;
        logic        hit;
        logic [31:0] d;
        logic [4:0]  done;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    // Expected values worked out from the requirements, 5 channels present
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b1, 32'h7FFF_FFFF, 5'b00000, 32'h809F_803F, 1'b1, 8'd2}, // R2 load, force -> R6
        '{1'b0, 1'b0, 32'h0000_0000, 5'b00000, 32'h809F_803F, 1'b0, 8'd6}, // R6 no repeat
        '{1'b1, 1'b1, 32'h0000_0000, 5'b00000, 32'h0000_0000, 1'b0, 8'd7}, // R7 master drops
        '{1'b1, 1'b1, 32'h0001_0000, 5'b00000, 32'h0001_0000, 1'b0, 8'd2},
        '{1'b0, 1'b0, 32'h0000_0000, 5'b00011, 32'h0101_0000, 1'b0, 8'd3}, // R3 ch1 ignored
        '{1'b1, 1'b1, 32'h0081_0000, 5'b00000, 32'h8181_0000, 1'b1, 8'd5}, // R5 global on
        '{1'b0, 1'b0, 32'h0000_0000, 5'b00001, 32'h8181_0000, 1'b0, 8'd6},
        '{1'b1, 1'b1, 32'h0181_0000, 5'b00000, 32'h0081_0000, 1'b0, 8'd4}, // R4 clear
        '{1'b0, 1'b0, 32'h0000_0000, 5'b00001, 32'h8181_0000, 1'b1, 8'd7}, // R7 re-arm
        '{1'b1, 1'b1, 32'h0181_0000, 5'b00001, 32'h8181_0000, 1'b0, 8'd4}, // R4 set wins
        '{1'b1, 1'b0, 32'h0000_0000, 5'b00000, 32'h8181_0000, 1'b0, 8'd8}, // R8 wrong addr
        '{1'b1, 1'b1, 32'h7F7F_8000, 5'b00000, 32'h801F_8000, 1'b0, 8'd9}, // R9 + force held
        '{1'b1, 1'b1, 32'h0000_0040, 5'b00000, 32'h0000_0000, 1'b0, 8'd2}, // bit 6 not loadable
        '{1'b1, 1'b1, 32'h009F_0000, 5'b00000, 32'h009F_0000, 1'b0, 8'd2},
        '{1'b0, 1'b0, 32'h0000_0000, 5'b11111, 32'h9F9F_0000, 1'b1, 8'd3},
        '{1'b1, 1'b1, 32'h029F_0000, 5'b00000, 32'h9D9F_0000, 1'b0, 8'd4}, // clear one of many
        '{1'b1, 1'b1, 32'h1D1F_0000, 5'b00000, 32'h001F_0000, 1'b0, 8'd7},
        '{1'b1, 1'b1, 32'h0000_0000, 5'b00100, 32'h0400_0000, 1'b0, 8'd3}, // R3 pre-write enable
        '{1'b1, 1'b1, 32'h0084_0000, 5'b00000, 32'h8484_0000, 1'b1, 8'd5}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset rd", rd_data, 32'h0);
        check("R1 reset irq", {31'h0, irq_set}, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en   = VEC[i].we;
            wr_addr = VEC[i].hit ? OFS : 12'h0F0;
            wr_data = VEC[i].d[30:0];
            ch_done = VEC[i].done;
            @(posedge clk);
            #1;
            check($sformatf("R%0d vec%0d rd", VEC[i].req, i), rd_data, VEC[i].exp_rd);
            check($sformatf("R%0d vec%0d irq", VEC[i].req, i), {31'h0, irq_set}, {31'h0, VEC[i].exp_irq});
        end

        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
        ch_done = '0;

        // R6: sustained master condition raises no further request
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            #1;
            check("R6 held irq", {31'h0, irq_set}, 32'h0);
            check("R8 idle rd", rd_data, 32'h8484_0000);
        end

        // R1: reset in the middle of operation
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 mid reset rd", rd_data, 32'h0);
        check("R1 mid reset irq", {31'h0, irq_set}, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // R3: completions with every enable clear are ignored
        @(negedge clk);
        ch_done = '1;
        @(posedge clk);
        #1;
        check("R3 disabled done rd", rd_data, 32'h0);
        check("R3 disabled done irq", {31'h0, irq_set}, 32'h0);
        @(negedge clk);
        ch_done = '0;

        summary();
        $finish;
    end

endmodule